// File: doc/BRIEF.md
# Audio Serial Port Power-State Controller

This block decides, for the transmit and receive sides of a serial audio port, when each serializer may run while the system asks for stop, low-leakage stop or a debug halt. A direction is never cut off in the middle of a frame. When a direction has to go quiet, it finishes the frame it is shifting and then parks. A direction that is not shifting a frame parks at once.

The block drives a stop acknowledge back to the power controller. The acknowledge is withheld while any direction that has to park is still inside a frame. The acknowledge is combinational on the request, so it drops in the same cycle the request is withdrawn. Each direction has its own stop-keep and debug-keep bits. The low-leakage flag overrides the stop-keep bits. A debug halt never stops the bit clock of an enabled direction.

Frame start and frame end arrive as one-cycle strobes from the serializers. These strobes are already synchronous to the block clock. Bit index 0 of every per-direction vector is transmit and bit index 1 is receive.

Top module: `audio_lp_ctrl`

## Requirements
- R1: While rst_ni is low and just after its release, active_o, tx_oe_o and stop_ack_o are all 0.
- R2: An enabled direction that has no reason to halt has active_o high one cycle after it is enabled. A frame_start_i pulse while it is armed starts a frame, which is visible on the next cycle.
- R3: A direction that is inside a frame keeps active_o high until its frame_end_i pulse if it must halt (stop requested with its stop_keep_i bit clear). active_o goes low on the cycle after that pulse.
- R4: During a stop request without low_leak_i, a direction whose stop_keep_i bit is 1 stays active and keeps starting frames.
- R5: stop_ack_o = stop_req_i AND no halting direction is inside a frame. It is combinational, so it deasserts in the same cycle stop_req_i drops.
- R6: With low_leak_i high, both stop_keep_i bits are ignored during a stop request. Both directions halt at frame end before the acknowledge.
- R7: During dbg_halt_i, a direction with dbg_keep_i = 0 halts at its frame end, and a direction with dbg_keep_i = 1 keeps running. Debug alone never raises stop_ack_o.
- R8: bclk_en_o[d] = active_o[d] OR (dbg_halt_i AND dir_en_i[d]), so an enabled direction keeps its bit clock throughout debug.
- R9: A direction that is disabled or armed but not inside a frame counts as halted at once. It does not delay the acknowledge, it drops active_o on the next cycle, and it ignores a frame_start_i pulse in that cycle.
- R10: After the request is removed, each enabled direction is active again on the next cycle. It shifts (tx_oe_o for transmit) only after the next frame_start_i.
- R11: tx_oe_o is high exactly while the transmit direction (index 0) is inside a frame.
- R12: Clearing dir_en_i mid-frame defers the shutdown of that direction to its frame end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_req_i | input | 1 | System stop request |
| low_leak_i | input | 1 | Stop is a low-leakage stop |
| dbg_halt_i | input | 1 | Debug halt of the system |
| dir_en_i | input | 2 | Software enable per direction (0 = tx, 1 = rx) |
| stop_keep_i | input | 2 | Keep running through ordinary stop |
| dbg_keep_i | input | 2 | Keep running through debug halt |
| frame_start_i | input | 2 | One-cycle frame start strobe |
| frame_end_i | input | 2 | One-cycle frame end strobe |
| active_o | output | 2 | Serializer permitted to run |
| bclk_en_o | output | 2 | Bit clock generator enable |
| tx_oe_o | output | 1 | Transmit data output enable |
| stop_ack_o | output | 1 | Stop acknowledge |

## Verification
The assertions take for granted that a frame_end_i pulse only comes while that direction is inside a frame. They also take for granted that frame_start_i does not arrive for a direction already inside a frame, which is what a real serializer guarantees. The random stimulus keeps to this by deriving each strobe from the bench's own model state before it drives the strobe. Requests and configuration bits are held for random stretches, so that stop, low-leakage and debug entries overlap with frames at every phase.

// File: rtl/alp_pkg.sv
package alp_pkg;
  typedef enum logic [1:0] {
    DIR_OFF   = 2'd0,
    DIR_ARMED = 2'd1,
    DIR_BUSY  = 2'd2
  } dir_st_e;

  localparam int TX_IDX = 0;
endpackage

// File: rtl/alp_halt_dec.sv
module alp_halt_dec #(
  parameter int N_DIR = 2
) (
  input  logic             stop_req_i,
  input  logic             low_leak_i,
  input  logic             dbg_halt_i,
  input  logic [N_DIR-1:0] dir_en_i,
  input  logic [N_DIR-1:0] stop_keep_i,
  input  logic [N_DIR-1:0] dbg_keep_i,
  output logic [N_DIR-1:0] halt_o,
  output logic [N_DIR-1:0] stop_due_o
);
  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    // low leakage overrides the keep bit
    assign stop_due_o[d] = low_leak_i | ~stop_keep_i[d];
    assign halt_o[d]     = ~dir_en_i[d]
                         | (stop_req_i & stop_due_o[d])
                         | (dbg_halt_i & ~dbg_keep_i[d]);
  end
endmodule

// File: rtl/alp_dir_fsm.sv
module alp_dir_fsm
  import alp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halt_i,
  input  logic sof_i,
  input  logic eof_i,
  output logic active_o,
  output logic busy_o
);
  dir_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      DIR_OFF:   if (!halt_i) st_d = DIR_ARMED;
      DIR_ARMED: begin
        if (halt_i)     st_d = DIR_OFF;   // idle: park now, start ignored
        else if (sof_i) st_d = DIR_BUSY;
      end
      DIR_BUSY:  if (eof_i) st_d = halt_i ? DIR_OFF : DIR_ARMED;
      default:   st_d = DIR_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= DIR_OFF;
    else         st_q <= st_d;
  end

  assign active_o = (st_q != DIR_OFF);
  assign busy_o   = (st_q == DIR_BUSY);
endmodule

// File: rtl/alp_ack.sv
module alp_ack #(
  parameter int N_DIR = 2
) (
  input  logic             stop_req_i,
  input  logic [N_DIR-1:0] stop_due_i,
  input  logic [N_DIR-1:0] busy_i,
  output logic             ack_o
);
  logic [N_DIR-1:0] pending;

  for (genvar d = 0; d < N_DIR; d++) begin : g_pend
    assign pending[d] = stop_due_i[d] & busy_i[d];
  end

  assign ack_o = stop_req_i & ~|pending;
endmodule

// File: rtl/audio_lp_ctrl.sv
module audio_lp_ctrl
  import alp_pkg::*;
#(
  parameter int N_DIR = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_req_i,
  input  logic             low_leak_i,
  input  logic             dbg_halt_i,
  input  logic [N_DIR-1:0] dir_en_i,
  input  logic [N_DIR-1:0] stop_keep_i,
  input  logic [N_DIR-1:0] dbg_keep_i,
  input  logic [N_DIR-1:0] frame_start_i,
  input  logic [N_DIR-1:0] frame_end_i,
  output logic [N_DIR-1:0] active_o,
  output logic [N_DIR-1:0] bclk_en_o,
  output logic             tx_oe_o,
  output logic             stop_ack_o
);
  logic [N_DIR-1:0] halt_w, due_w, busy_w;

  alp_halt_dec #(.N_DIR(N_DIR)) u_dec (
    .stop_req_i (stop_req_i),
    .low_leak_i (low_leak_i),
    .dbg_halt_i (dbg_halt_i),
    .dir_en_i   (dir_en_i),
    .stop_keep_i(stop_keep_i),
    .dbg_keep_i (dbg_keep_i),
    .halt_o     (halt_w),
    .stop_due_o (due_w)
  );

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    alp_dir_fsm u_fsm (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .halt_i  (halt_w[d]),
      .sof_i   (frame_start_i[d]),
      .eof_i   (frame_end_i[d]),
      .active_o(active_o[d]),
      .busy_o  (busy_w[d])
    );
    // bit clock survives debug for any enabled direction
    assign bclk_en_o[d] = active_o[d] | (dbg_halt_i & dir_en_i[d]);
  end

  alp_ack #(.N_DIR(N_DIR)) u_ack (
    .stop_req_i(stop_req_i),
    .stop_due_i(due_w),
    .busy_i    (busy_w),
    .ack_o     (stop_ack_o)
  );

  assign tx_oe_o = busy_w[TX_IDX];
endmodule

// File: rtl/alp_checker.sv
module alp_checker
  import alp_pkg::*;
#(
  parameter int N_DIR = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             stop_req_i,
  input logic             low_leak_i,
  input logic             dbg_halt_i,
  input logic [N_DIR-1:0] dir_en_i,
  input logic [N_DIR-1:0] stop_keep_i,
  input logic [N_DIR-1:0] frame_end_i,
  input logic [N_DIR-1:0] busy_w,
  input logic [N_DIR-1:0] active_o,
  input logic [N_DIR-1:0] bclk_en_o,
  input logic             tx_oe_o,
  input logic             stop_ack_o
);
  a_r5_ack_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_ack_o |-> stop_req_i);

  a_r11_oe_implies_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_oe_o |-> active_o[TX_IDX]);

  for (genvar d = 0; d < N_DIR; d++) begin : g_chk
    a_r3_frame_ends_on_eof: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_w[d]) |-> $past(frame_end_i[d]));

    a_r12_no_midframe_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(active_o[d]) |-> ($past(!busy_w[d]) || $past(frame_end_i[d])));

    a_r5_no_ack_while_due_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stop_ack_o && busy_w[d]) |-> (!low_leak_i && stop_keep_i[d]));

    a_r8_bclk_in_debug: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dbg_halt_i && dir_en_i[d]) |-> bclk_en_o[d]);

    a_r4_keep_through_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stop_req_i && !low_leak_i && stop_keep_i[d] && !dbg_halt_i
       && dir_en_i[d] && active_o[d]) |=> active_o[d]);
  end
endmodule

bind audio_lp_ctrl alp_checker #(.N_DIR(N_DIR)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stop_req_i (stop_req_i),
  .low_leak_i (low_leak_i),
  .dbg_halt_i (dbg_halt_i),
  .dir_en_i   (dir_en_i),
  .stop_keep_i(stop_keep_i),
  .frame_end_i(frame_end_i),
  .busy_w     (busy_w),
  .active_o   (active_o),
  .bclk_en_o  (bclk_en_o),
  .tx_oe_o    (tx_oe_o),
  .stop_ack_o (stop_ack_o)
);

// File: tb/audio_lp_ctrl_tb.sv
module audio_lp_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 0, low_leak = 0, dbg_halt = 0;
  logic [1:0] en = 0, skeep = 0, dkeep = 0, fs = 0, fe = 0;
  logic [1:0] active, bclk_en;
  logic tx_oe, ack;

  int n_tests = 0, n_fail = 0;
  int ms [2];  // model: 0 off, 1 armed, 2 busy

  always #10 clk = ~clk;

  audio_lp_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .stop_req_i(stop_req), .low_leak_i(low_leak),
    .dbg_halt_i(dbg_halt), .dir_en_i(en), .stop_keep_i(skeep), .dbg_keep_i(dkeep),
    .frame_start_i(fs), .frame_end_i(fe), .active_o(active), .bclk_en_o(bclk_en),
    .tx_oe_o(tx_oe), .stop_ack_o(ack)
  );

  task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string req);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit m_halt(int d);
    return !en[d] || (stop_req && (low_leak || !skeep[d])) || (dbg_halt && !dkeep[d]);
  endfunction

  function automatic logic m_ack();
    logic a = stop_req;
    for (int d = 0; d < 2; d++)
      if ((low_leak || !skeep[d]) && ms[d] == 2) a = 0;
    return a;
  endfunction

  function automatic logic [1:0] m_active();
    return {ms[1] != 0, ms[0] != 0};
  endfunction

  function automatic logic [1:0] m_bclk();
    logic [1:0] b;
    for (int d = 0; d < 2; d++) b[d] = (ms[d] != 0) || (dbg_halt && en[d]);
    return b;
  endfunction

  // check against model, advance one edge, clear strobes
  task automatic step();
    int nx [2];
    #2;
    chk(active, m_active(), "R3");
    chk({1'b0, tx_oe}, {1'b0, ms[0] == 2}, "R11");
    chk({1'b0, ack}, {1'b0, m_ack()}, "R5");
    chk(bclk_en, m_bclk(), "R8");
    for (int d = 0; d < 2; d++) begin
      nx[d] = ms[d];
      case (ms[d])
        0: if (!m_halt(d)) nx[d] = 1;
        1: if (m_halt(d)) nx[d] = 0; else if (fs[d]) nx[d] = 2;
        default: if (fe[d]) nx[d] = m_halt(d) ? 0 : 1;
      endcase
    end
    @(posedge clk);
    ms[0] = nx[0]; ms[1] = nx[1];
    #2;
    fs = 0; fe = 0;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    ms[0] = 0; ms[1] = 0;
    repeat (3) @(posedge clk);
    #2;
    chk(active, 2'b00, "R1"); chk({1'b0, tx_oe}, 2'b00, "R1"); chk({1'b0, ack}, 2'b00, "R1");
    rst_n = 1;
    @(posedge clk); #2;
    chk(active, 2'b00, "R1");
    // R2 enable and start
    en = 2'b11; step();
    chk(active, 2'b11, "R2");
    fs = 2'b11; step();
    chk({1'b0, tx_oe}, 2'b01, "R2");
    // R3/R5 stop with keep clear
    stop_req = 1; #1;
    chk({1'b0, ack}, 2'b00, "R5");
    step();
    chk(active, 2'b11, "R3");
    fe = 2'b01; step();
    chk(active, 2'b10, "R3"); chk({1'b0, ack}, 2'b00, "R5");
    fe = 2'b10; step();
    chk(active, 2'b00, "R3"); chk({1'b0, ack}, 2'b01, "R5");
    stop_req = 0; #1;
    chk({1'b0, ack}, 2'b00, "R5");
    step();
    chk(active, 2'b11, "R10"); chk({1'b0, tx_oe}, 2'b00, "R10");
    fs = 2'b01; step();
    chk({1'b0, tx_oe}, 2'b01, "R10");
    // R4 keep tx, rx idle -> R9
    skeep = 2'b01; stop_req = 1; #1;
    chk({1'b0, ack}, 2'b01, "R9");
    step();
    chk(active, 2'b01, "R9");
    fe = 2'b01; step();
    chk(active, 2'b01, "R4");
    fs = 2'b01; step();
    chk({1'b0, tx_oe}, 2'b01, "R4");
    // R6 low leakage overrides keep
    low_leak = 1; #1;
    chk({1'b0, ack}, 2'b00, "R6");
    step();
    fe = 2'b01; step();
    chk(active, 2'b00, "R6"); chk({1'b0, ack}, 2'b01, "R6");
    stop_req = 0; low_leak = 0; skeep = 0; step();
    // R9 armed directions ignore start when halting
    stop_req = 1; fs = 2'b11; step();
    chk(active, 2'b00, "R9"); chk({1'b0, tx_oe}, 2'b00, "R9");
    stop_req = 0; step();
    // R7/R8 debug
    fs = 2'b11; step();
    dbg_halt = 1; dkeep = 2'b10; #1;
    chk({1'b0, ack}, 2'b00, "R7"); chk(bclk_en, 2'b11, "R8");
    step();
    fe = 2'b11; step();
    chk(active, 2'b10, "R7"); chk(bclk_en, 2'b11, "R8");
    dbg_halt = 0; dkeep = 0; step();
    // R12 disable mid-frame
    fs = 2'b01; step();
    en = 2'b10; step();
    chk(active[0], 1'b1, "R12");
    fe = 2'b01; step();
    chk(active[0], 1'b0, "R12"); chk(bclk_en[0], 1'b0, "R12");
    en = 2'b11; step();
    // random phase
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(9) == 0) stop_req = ~stop_req;
      if ($urandom_range(15) == 0) low_leak = ~low_leak;
      if ($urandom_range(15) == 0) dbg_halt = ~dbg_halt;
      if ($urandom_range(19) == 0) en = 2'($urandom);
      if ($urandom_range(11) == 0) skeep = 2'($urandom);
      if ($urandom_range(11) == 0) dkeep = 2'($urandom);
      for (int d = 0; d < 2; d++) begin
        if (ms[d] == 2) fe[d] = ($urandom_range(3) == 0);
        else            fs[d] = ($urandom_range(2) == 0);
      end
      step();
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule